// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

The block collects 64 interrupt inputs and gives each a one-byte control field. That byte enables the source, picks its trigger type and picks where it is routed. A level source counts as pending while its input is high. An edge source records its event in a status bit that software clears by writing a 1 to it. Among the pending sources that are enabled and routed to the normal interrupt line, an arbiter picks one winner. Its index is kept in a readable highest-priority register, and the normal interrupt output is raised. Sources routed to the fast interrupt line drive a second output.

Software reaches everything through a simple word-wide register bus with byte enables. Reads return data combinationally. A write takes effect at the clock edge on which it is presented. The arbiter has two modes. In fixed mode the lowest source number wins. In rotating mode the search starts at a base index, and each read of the highest-priority register moves that base to just past the source it reported, so the source just served becomes the last choice.

Top module: `prio_intc`

## Requirements
- R1: There are 64 sources. Source n has a control byte in the word at address 0x40 + 4*(n/4), in byte lane n%4, written under the byte enables. Bit 3 of the byte is the enable, and a disabled source never reaches an output or the arbiter. Every control byte resets to 0x00, which means disabled and routed to the normal line.
- R2: Control bit 5 selects a rising-edge trigger and bit 6 selects a falling-edge trigger. Setting both catches either edge. With both bits clear the source is level-sensitive and counts as pending only while its input is high.
- R3: An edge of the selected polarity sets status bit n%32, in the word at 0x80 for sources 0 to 31 and in the word at 0x84 for sources 32 to 63. The bit is set whether or not the source is enabled.
- R4: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. If a new edge arrives in the same cycle as the clear, the bit stays set.
- R5: Control bits 2:0 pick the destination: 0 is the normal line irq_o, 1 is the fast line fiq_o, and values 2 to 7 reach neither output. Each output is the OR of the enabled, pending sources routed to it, registered once.
- R6: A read at 0x00 returns in bits 5:0 the arbitration winner, registered once. The value is 63 when no source is pending for the normal line. Bit 31 of the word at 0x84 tells an edge-latched source 63 apart from "none".
- R7: The register at 0x20 holds a rotate flag in bit 6 and a base index in bits 5:0, and resets to 0. With the flag clear, the lowest pending source number wins.
- R8: With the flag set, the winner is the first pending source at or above the base, wrapping around past 63. A read of 0x00 while a winner is present sets the base to that winner plus one, modulo 64. In fixed mode a read of 0x00 leaves the base unchanged.
- R9: The register at 0x24 stores the fast-line priority control in bits 6:0, resets to 0 and reads back as written.
- R10: Clearing the enable bit of a pending source drops it from the outputs at the clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Interrupt source inputs |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address, word aligned |
| be_i | input | 4 | Write byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Normal interrupt output, registered |
| fiq_o | output | 1 | Fast interrupt output, registered |

## Verification
A corrupted control byte shows up at the next register read. It also misroutes the source, and that shows on irq_o, fiq_o or the index register one edge after the source becomes pending. A stuck or lost edge latch shows in the status words one edge after the edge. A wrong rotation base shows as a wrong index within two edges of the read that moved it. The bench therefore reads back the index and the status words a couple of edges after every change. Directed edge, collision and wrap cases are mixed with seeded random level patterns and routings.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int CB_EN   = 3;
  localparam int CB_RISE = 5;
  localparam int CB_FALL = 6;
  localparam logic [2:0] DST_IRQ = 3'd0;
  localparam logic [2:0] DST_FIQ = 3'd1;

  localparam logic [7:0] A_HP  = 8'h00;
  localparam logic [7:0] A_IPC = 8'h20;
  localparam logic [7:0] A_FPC = 8'h24;
  localparam logic [7:0] A_ST0 = 8'h80;
  localparam logic [7:0] A_ST1 = 8'h84;

  typedef struct packed {
    logic       rot;
    logic [5:0] base;
  } pctl_t;
endpackage

// File: rtl/prio_intc_edge.sv
module prio_intc_edge #(
  parameter int NS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] src_i,
  input  logic [NS-1:0] rise_en_i,
  input  logic [NS-1:0] fall_en_i,
  input  logic [NS-1:0] clr_i,
  output logic [NS-1:0] pend_o
);
  logic [NS-1:0] src_q, pend_q, set;

  assign set = (src_i & ~src_q & rise_en_i) | (~src_i & src_q & fall_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      pend_q <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_i) | set;  // new edge beats clear
    end
  end

  assign pend_o = pend_q;

  assert_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(set)) == $past(set)));
  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & $past(clr_i & ~set)) == '0));
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
  parameter int NS = 64,
  localparam int IW = $clog2(NS)
) (
  input  logic [NS-1:0] cand_i,
  input  logic          rot_i,
  input  logic [IW-1:0] base_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  logic [NS-1:0] upper;

  function automatic logic [IW-1:0] first1(input logic [NS-1:0] v);
    first1 = '0;
    for (int i = NS - 1; i >= 0; i--) if (v[i]) first1 = IW'(i);
  endfunction

  assign upper = cand_i & ({NS{1'b1}} << base_i);
  assign any_o = |cand_i;

  always_comb begin
    if (rot_i && |upper) idx_o = first1(upper);
    else                 idx_o = first1(cand_i);
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NS = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] src_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [7:0]    addr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int IW = $clog2(NS);
  localparam int NW = NS / 4;

  logic [7:0]    ctl_q [NS];
  logic [NS-1:0] rise_en, fall_en, clr, epend, irq_cand, fiq_cand;
  logic [31:0]   bmask;
  logic          wr, rd_hp, ipc_wr, fpc_wr, ctl_sel, any;
  logic [IW-1:0] idx, hp_q;
  logic          hp_vld_q, irq_q, fiq_q;
  pctl_t         ipc_q, fpc_q;

  assign wr      = req_i & we_i;
  assign rd_hp   = req_i & ~we_i & (addr_i == A_HP);
  assign ipc_wr  = wr & (addr_i == A_IPC) & be_i[0];
  assign fpc_wr  = wr & (addr_i == A_FPC) & be_i[0];
  assign ctl_sel = (addr_i[7:6] == 2'b01) & (addr_i[1:0] == 2'b00);
  assign bmask   = {{8{be_i[3]}}, {8{be_i[2]}}, {8{be_i[1]}}, {8{be_i[0]}}};

  assign clr[31:0]    = (wr && addr_i == A_ST0) ? (wdata_i & bmask) : '0;
  assign clr[NS-1:32] = (wr && addr_i == A_ST1) ? (wdata_i & bmask) : '0;

  for (genvar n = 0; n < NS; n++) begin : g_src
    logic sel, lvl, pend;
    assign sel = wr & ctl_sel & (addr_i[5:2] == 4'(n / 4)) & be_i[n % 4];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ctl_q[n] <= '0;
      else if (sel) ctl_q[n] <= wdata_i[8*(n%4) +: 8];
    end
    assign rise_en[n]  = ctl_q[n][CB_RISE];
    assign fall_en[n]  = ctl_q[n][CB_FALL];
    assign lvl         = ~rise_en[n] & ~fall_en[n];
    assign pend        = ctl_q[n][CB_EN] & (lvl ? src_i[n] : epend[n]);
    assign irq_cand[n] = pend & (ctl_q[n][2:0] == DST_IRQ);
    assign fiq_cand[n] = pend & (ctl_q[n][2:0] == DST_FIQ);
  end

  prio_intc_edge #(.NS(NS)) u_edge (
    .clk_i, .rst_ni, .src_i,
    .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_i(clr), .pend_o(epend)
  );

  prio_intc_arb #(.NS(NS)) u_arb (
    .cand_i(irq_cand), .rot_i(ipc_q.rot), .base_i(ipc_q.base),
    .any_o(any), .idx_o(idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ipc_q    <= '0;
      fpc_q    <= '0;
      hp_q     <= '1;
      hp_vld_q <= 1'b0;
      irq_q    <= 1'b0;
      fiq_q    <= 1'b0;
    end else begin
      if (ipc_wr)                              ipc_q <= pctl_t'(wdata_i[6:0]);
      else if (rd_hp && hp_vld_q && ipc_q.rot) ipc_q.base <= hp_q + 1'b1;
      if (fpc_wr) fpc_q <= pctl_t'(wdata_i[6:0]);
      hp_q     <= any ? idx : '1;
      hp_vld_q <= any;
      irq_q    <= |irq_cand;
      fiq_q    <= |fiq_cand;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctl_sel) begin
      for (int b = 0; b < 4; b++) rdata_o[8*b +: 8] = ctl_q[{addr_i[5:2], 2'(b)}];
    end else begin
      case (addr_i)
        A_HP:    rdata_o = 32'(hp_q);
        A_IPC:   rdata_o = 32'(ipc_q);
        A_FPC:   rdata_o = 32'(fpc_q);
        A_ST0:   rdata_o = epend[31:0];
        A_ST1:   rdata_o = epend[NS-1:32];
        default: rdata_o = '0;
      endcase
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  assert_irq_vld_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> hp_vld_q);
  assert_idle_hp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (hp_q == '1));
  assert_hp_cand_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_vld_q |-> |($past(irq_cand) & (NS'(1) << hp_q)));
  assert_fixed_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hp_vld_q && !$past(ipc_q.rot)) |-> (($past(irq_cand) & ((NS'(1) << hp_q) - NS'(1))) == '0));
  assert_rot_base_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hp && hp_vld_q && ipc_q.rot && !ipc_wr) |=> (ipc_q.base == IW'($past(hp_q) + 1'b1)));
endmodule

// File: tb/prio_intc_test.sv
`timescale 1ns/1ps
module prio_intc_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0, rdata, d;
  logic        irq, fiq;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  ctl_m [64];

  always #2.5 clk = ~clk;

  prio_intc uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] dt, input logic [3:0] b);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = dt; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] dt);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 dt = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic set_ctl(input int n, input logic [7:0] v);
    ctl_m[n] = v;
    wr(8'h40 + 8'(4 * (n / 4)), 32'(v) << (8 * (n % 4)), 4'b0001 << (n % 4));
  endtask

  function automatic logic exp_out(input logic [63:0] s, input logic [2:0] dst);
    exp_out = 1'b0;
    for (int n = 0; n < 64; n++)
      if (ctl_m[n][3] && s[n] && ctl_m[n][2:0] == dst) exp_out = 1'b1;
  endfunction

  function automatic logic [31:0] exp_hp(input logic [63:0] s);
    exp_hp = 32'd63;
    for (int n = 63; n >= 0; n--)
      if (ctl_m[n][3] && s[n] && ctl_m[n][2:0] == 3'd0) exp_hp = 32'(n);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int n = 0; n < 64; n++) ctl_m[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // reset state
    rd(8'h00, d); chk("R6 reset index", d, 32'd63);
    chk("R5 reset irq", 32'(irq), 0);
    chk("R5 reset fiq", 32'(fiq), 0);
    rd(8'h40, d); chk("R1 reset ctl word 0", d, 0);
    rd(8'h7C, d); chk("R1 reset ctl word 15", d, 0);
    rd(8'h20, d); chk("R7 reset prio ctl", d, 0);
    rd(8'h24, d); chk("R9 reset fast ctl", d, 0);

    // R9 fast-line priority control storage
    wr(8'h24, 32'h5A, 4'hF);
    rd(8'h24, d); chk("R9 fast ctl readback", d, 32'h5A);
    wr(8'h24, 32'h0, 4'hF);

    // R1 disabled level source stays silent
    src[5] = 1'b1;
    set_ctl(5, 8'h00);
    idle(2);
    chk("R1 disabled no irq", 32'(irq), 0);
    // R1 byte-lane write enables source 5
    set_ctl(5, 8'h08);
    rd(8'h44, d); chk("R1 byte lane readback", d, 32'h0000_0800);
    idle(1);
    chk("R2 level irq", 32'(irq), 1);
    rd(8'h00, d); chk("R6 index level 5", d, 5);

    // R10 disable timing: output registered once after the write edge
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 8'h44; wdata = 32'h0; be = 4'b0010;
    @(posedge clk); #1 chk("R5 output still registered", 32'(irq), 1);
    @(negedge clk); req = 1'b0; we = 1'b0; be = '0;
    ctl_m[5] = 8'h00;
    @(posedge clk); #1 chk("R10 drop after disable", 32'(irq), 0);
    src[5] = 1'b0;

    // R2 level follows input
    set_ctl(6, 8'h08);
    src[6] = 1'b1; idle(2);
    chk("R2 level high", 32'(irq), 1);
    src[6] = 1'b0; idle(2);
    chk("R2 level low", 32'(irq), 0);
    set_ctl(6, 8'h00);

    // R2/R3 rising edge on source 40
    set_ctl(40, 8'h28);
    src[40] = 1'b1; idle(1); src[40] = 1'b0; idle(2);
    chk("R2 rising latched irq", 32'(irq), 1);
    rd(8'h84, d); chk("R3 status hi bit 8", d, 32'h100);
    rd(8'h00, d); chk("R6 index 40", d, 40);

    // R4 write-zero then write-one
    wr(8'h84, 32'h0, 4'hF);
    rd(8'h84, d); chk("R4 zero write keeps", d, 32'h100);
    wr(8'h84, 32'h100, 4'hF); idle(1);
    rd(8'h84, d); chk("R4 one write clears", d, 0);
    chk("R4 irq gone", 32'(irq), 0);
    rd(8'h00, d); chk("R6 index none", d, 63);
    set_ctl(40, 8'h00);

    // R2 falling edge on source 33
    set_ctl(33, 8'h40);
    src[33] = 1'b1; idle(2);
    rd(8'h84, d); chk("R2 falling ignores rise", d, 0);
    src[33] = 1'b0; idle(2);
    rd(8'h84, d); chk("R2 falling latched", d, 32'h2);
    wr(8'h84, 32'h2, 4'hF);
    set_ctl(33, 8'h00);

    // R2 both edges on source 2
    set_ctl(2, 8'h60);
    src[2] = 1'b1; idle(2);
    rd(8'h80, d); chk("R2 both: rise", d, 32'h4);
    wr(8'h80, 32'h4, 4'hF);
    src[2] = 1'b0; idle(2);
    rd(8'h80, d); chk("R2 both: fall", d, 32'h4);
    wr(8'h80, 32'h4, 4'hF);
    set_ctl(2, 8'h00);

    // R3 latch while disabled, then enable
    set_ctl(10, 8'h20);
    src[10] = 1'b1; idle(1); src[10] = 1'b0; idle(2);
    rd(8'h80, d); chk("R3 latched while disabled", d, 32'h400);
    chk("R3 disabled no irq", 32'(irq), 0);
    set_ctl(10, 8'h28); idle(1);
    chk("R3 enable shows irq", 32'(irq), 1);
    rd(8'h00, d); chk("R3 index 10", d, 10);
    set_ctl(10, 8'h20);
    wr(8'h80, 32'h400, 4'hF);

    // R4 edge and clear in the same cycle: set wins
    @(negedge clk);
    src[10] = 1'b1;
    req = 1'b1; we = 1'b1; addr = 8'h80; wdata = 32'h400; be = 4'hF;
    @(negedge clk); req = 1'b0; we = 1'b0; be = '0;
    rd(8'h80, d); chk("R4 set beats clear", d, 32'h400);
    src[10] = 1'b0;
    wr(8'h80, 32'h400, 4'hF);
    set_ctl(10, 8'h00);

    // R5 destination routing
    set_ctl(20, 8'h09); src[20] = 1'b1; idle(2);
    chk("R5 fiq route", 32'(fiq), 1);
    chk("R5 fiq not irq", 32'(irq), 0);
    rd(8'h00, d); chk("R5 fiq not arbitrated", d, 63);
    set_ctl(20, 8'h0B); idle(2);
    chk("R5 dest3 no fiq", 32'(fiq), 0);
    chk("R5 dest3 no irq", 32'(irq), 0);
    src[20] = 1'b0; set_ctl(20, 8'h00);

    // R6 edge-latched source 63
    set_ctl(63, 8'h28);
    src[63] = 1'b1; idle(2);
    rd(8'h00, d); chk("R6 index 63 real", d, 63);
    chk("R6 irq for 63", 32'(irq), 1);
    rd(8'h84, d); chk("R6 status bit 31", d, 32'h8000_0000);
    wr(8'h84, 32'h8000_0000, 4'hF);
    src[63] = 1'b0; set_ctl(63, 8'h00);

    // R7 fixed priority
    set_ctl(7, 8'h08); set_ctl(12, 8'h08); set_ctl(50, 8'h08);
    src[7] = 1'b1; src[12] = 1'b1; src[50] = 1'b1; idle(2);
    rd(8'h00, d); chk("R7 fixed lowest", d, 7);
    idle(2);
    rd(8'h00, d); chk("R7 fixed repeat", d, 7);

    // R8 rotating priority
    wr(8'h20, 32'h40, 4'hF); idle(2);
    rd(8'h00, d); chk("R8 rot first", d, 7);
    idle(2); rd(8'h00, d); chk("R8 rot second", d, 12);
    idle(2); rd(8'h00, d); chk("R8 rot third", d, 50);
    idle(2); rd(8'h00, d); chk("R8 rot wrap", d, 7);
    rd(8'h20, d); chk("R8 base after wrap", d, 32'h48);
    wr(8'h20, 32'h40 | 32'd13, 4'hF); idle(2);
    rd(8'h00, d); chk("R8 base 13", d, 50);
    wr(8'h20, 32'h05, 4'hF); idle(2);
    rd(8'h00, d); chk("R8 fixed read", d, 7);
    rd(8'h20, d); chk("R8 fixed base kept", d, 32'h05);
    wr(8'h20, 32'h0, 4'hF);
    src = '0;
    set_ctl(7, 8'h00); set_ctl(12, 8'h00); set_ctl(50, 8'h00);

    // random level patterns and routings, fixed mode
    for (int it = 0; it < 200; it++) begin
      if (it % 20 == 0) begin
        for (int k = 0; k < 16; k++) begin
          logic [31:0] w;
          w = '0;
          for (int b = 0; b < 4; b++) begin
            logic [7:0] v;
            v = {4'b0, 1'($urandom % 2), 3'($urandom % 4)};
            ctl_m[4 * k + b] = v;
            w[8 * b +: 8] = v;
          end
          wr(8'h40 + 8'(4 * k), w, 4'hF);
        end
      end
      src = {$urandom, $urandom} & {$urandom, $urandom};
      idle(2);
      chk("R5 random irq", 32'(irq), 32'(exp_out(src, 3'd0)));
      chk("R5 random fiq", 32'(fiq), 32'(exp_out(src, 3'd1)));
      rd(8'h00, d); chk("R7 random index", d, exp_hp(src));
    end

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule